// File: doc/BRIEF.md
# Two-Phase Fetch-Execute Processor Core

This block is a compact 16-bit processor in which every instruction takes exactly two clock cycles. A one-bit phase register alternates between a fetch cycle, which copies the word at the program counter into the instruction register and advances the counter, and an execute cycle, which performs the operation. Register-file and memory writes happen only at the clock edge that closes the execute cycle. Every operand is therefore read from state that is stable for the whole cycle, so an instruction can name the same register as source and destination.

The core contains a 256-word by 16-bit memory, sixteen 16-bit registers with two read ports and one write port, an 8-bit program counter, the instruction register, an ALU and the control logic. It runs a sixteen-opcode instruction set: arithmetic, logic, shifts, direct and indirect memory access, two conditional branches, jump-through-register and jump-and-link. While the core is held in reset, a test harness fills memory through a load port. The same port reads memory back, and a debug output shows the program counter. A halt instruction stops the core until the next reset.

Top module: `twophase_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_dbg` equals the `START` parameter (default 8'h10), `halted` is 0, all registers are zero, and the next cycle after release is a fetch.
- R2: A fetch cycle loads the instruction register from memory at the PC and sets the PC to PC+1 (mod 256). It is always followed by one execute cycle. A program of N instructions ending in halt raises `halted` exactly 2N rising edges after reset release.
- R3: Register and memory writes commit only at the edge that ends an execute cycle. Operands are read before the write, so instruction 0x1111 doubles R1.
- R4: An instruction word holds the opcode in bits [15:12], the destination d in [11:8], source s in [7:4], source t in [3:0], and an 8-bit address in [7:0]. Opcodes 1 to 6 write R[d] with R[s]+R[t], R[s]-R[t], R[s]&R[t], R[s]^R[t], R[s] shifted left by R[t][3:0], and R[s] shifted right arithmetically (sign-filling) by R[t][3:0]. Results wrap modulo 2^16.
- R5: Opcode 7 writes R[d] with the zero-extended address field. Opcode 8 writes R[d] with mem[addr]. Opcode 9 writes mem[addr] with R[d].
- R6: Opcode A writes R[d] with mem[R[t][7:0]]. Opcode B writes mem[R[t][7:0]] with R[d]. The upper byte of R[t] is ignored.
- R7: Opcode C sets the PC to the address field when R[d] is zero. Opcode D does so when R[d] is nonzero with bit 15 clear. Otherwise execution continues at PC+1.
- R8: Opcode E sets the PC to R[d][7:0]. Opcode F writes R[d] with the already-incremented PC, zero-extended, and sets the PC to the address field.
- R9: R0 always reads as zero. Writes to R0 have no effect.
- R10: Opcode 0 sets `halted`. From then until reset, the PC and phase hold, and no register or memory write occurs.
- R11: A high `ld_we` writes `ld_wdata` into mem[`ld_addr`] at the clock edge. `ld_rdata` always shows mem[`ld_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 8 | Load-port memory address |
| ld_wdata | input | 16 | Load-port write data |
| ld_rdata | output | 16 | Memory word at `ld_addr` |
| halted | output | 1 | Sticky halt flag |
| pc_dbg | output | 8 | Current program counter |

## Verification
A corrupted phase bit or program counter shows up on `pc_dbg` and in the number of cycles before `halted` rises. The edge count is off by one or more within the same instruction. A wrong register value stays hidden until a later store, branch or jump consumes it. Each test program therefore routes every result to a memory word read back through `ld_rdata`, or to a branch whose target shows in the final PC, within two or three instructions of the faulty write.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

    typedef enum logic [3:0] {
        OP_HALT = 4'h0,
        OP_ADD  = 4'h1,
        OP_SUB  = 4'h2,
        OP_AND  = 4'h3,
        OP_XOR  = 4'h4,
        OP_SHL  = 4'h5,
        OP_SHR  = 4'h6,
        OP_LDA  = 4'h7,
        OP_LD   = 4'h8,
        OP_ST   = 4'h9,
        OP_LDI  = 4'hA,
        OP_STI  = 4'hB,
        OP_BZ   = 4'hC,
        OP_BP   = 4'hD,
        OP_JR   = 4'hE,
        OP_JAL  = 4'hF
    } opcode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_XOR = 3'd3,
        ALU_SHL = 3'd4,
        ALU_SHR = 3'd5
    } alu_op_e;

endpackage

// File: rtl/tp_alu.sv
module tp_alu
    import twophase_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh_amt;
    assign sh_amt = b[SHW-1:0];

    always_comb begin
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            ALU_SHL: y = a << sh_amt;
            ALU_SHR: y = W'($signed(a) >>> sh_amt);
            default: y = a;
        endcase
    end
endmodule

// File: rtl/tp_regfile.sv
module tp_regfile #(
    parameter int W    = 16,
    parameter int NREG = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  ra_addr,
    output logic [W-1:0]             ra_data,
    input  logic [$clog2(NREG)-1:0]  rb_addr,
    output logic [W-1:0]             rb_data,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [W-1:0]             wdata
);
    localparam int RW = $clog2(NREG);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != RW'(0)))
            regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    assign ra_data = (ra_addr == RW'(0)) ? '0 : regs_q[ra_addr];
    assign rb_data = (rb_addr == RW'(0)) ? '0 : regs_q[rb_addr];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != RW'(0)) |=> (regs_q[$past(waddr)] == $past(wdata)));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == RW'(0)) |=> (ra_addr != RW'(0) || ra_data == '0));
endmodule

// File: rtl/tp_memory.sv
module tp_memory #(
    parameter int W     = 16,
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic [$clog2(DEPTH)-1:0]   core_addr,
    output logic [W-1:0]               core_rdata,
    input  logic                       core_we,
    input  logic [W-1:0]               core_wdata,
    input  logic                       ld_we,
    input  logic [$clog2(DEPTH)-1:0]   ld_addr,
    input  logic [W-1:0]               ld_wdata,
    output logic [W-1:0]               ld_rdata
);
    logic [W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we)        words_q[ld_addr]   <= ld_wdata;
        else if (core_we) words_q[core_addr] <= core_wdata;
    end

    assign core_rdata = words_q[core_addr];
    assign ld_rdata   = words_q[ld_addr];

    // R11
    load_write_chk: assert property (@(posedge clk)
        ld_we |=> (words_q[$past(ld_addr)] == $past(ld_wdata)));
endmodule

// File: rtl/twophase_cpu.sv
module twophase_cpu
    import twophase_pkg::*;
#(
    parameter int             W     = 16,
    parameter int             AW    = 8,
    parameter int             NREG  = 16,
    parameter logic [AW-1:0]  START = 'h10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_we,
    input  logic [AW-1:0]  ld_addr,
    input  logic [W-1:0]   ld_wdata,
    output logic [W-1:0]   ld_rdata,
    output logic           halted,
    output logic [AW-1:0]  pc_dbg
);
    localparam int RW    = $clog2(NREG);
    localparam int DEPTH = 1 << AW;
    localparam int OPW   = 4;

    typedef struct packed {
        logic          halted;
        phase_e        phase;
        logic [W-1:0]  ir;
        logic [AW-1:0] pc;
    } core_state_t;

    core_state_t st_q, st_d;

    opcode_e        op;
    logic [RW-1:0]  fld_dst, fld_src, fld_tgt;
    logic [AW-1:0]  fld_addr;
    logic           reads_dst;

    logic [RW-1:0]  rf_ra;
    logic [W-1:0]   ra_val, rb_val;
    logic           rf_we;
    logic [W-1:0]   rf_wdata;

    logic [AW-1:0]  mem_addr;
    logic [W-1:0]   mem_rdata;
    logic           mem_we;

    alu_op_e        alu_sel;
    logic [W-1:0]   alu_y;
    logic           is_zero, is_pos;

    assign op       = opcode_e'(st_q.ir[W-1 -: OPW]);
    assign fld_dst  = st_q.ir[W-OPW-1 -: RW];
    assign fld_src  = st_q.ir[W-OPW-RW-1 -: RW];
    assign fld_tgt  = st_q.ir[RW-1:0];
    assign fld_addr = st_q.ir[AW-1:0];

    assign reads_dst = op inside {OP_ST, OP_STI, OP_BZ, OP_BP, OP_JR};
    assign rf_ra     = reads_dst ? fld_dst : fld_src;

    assign is_zero = (ra_val == '0);
    assign is_pos  = !ra_val[W-1] && !is_zero;

    always_comb begin
        if (st_q.phase == PH_FETCH)       mem_addr = st_q.pc;
        else if (op inside {OP_LD, OP_ST}) mem_addr = fld_addr;
        else                               mem_addr = rb_val[AW-1:0];
    end

    always_comb begin
        unique case (op)
            OP_SUB:  alu_sel = ALU_SUB;
            OP_AND:  alu_sel = ALU_AND;
            OP_XOR:  alu_sel = ALU_XOR;
            OP_SHL:  alu_sel = ALU_SHL;
            OP_SHR:  alu_sel = ALU_SHR;
            default: alu_sel = ALU_ADD;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        rf_we    = 1'b0;
        rf_wdata = alu_y;
        mem_we   = 1'b0;
        if (!st_q.halted) begin
            if (st_q.phase == PH_FETCH) begin
                st_d.ir    = mem_rdata;
                st_d.pc    = st_q.pc + 1'b1;
                st_d.phase = PH_EXEC;
            end else begin
                st_d.phase = PH_FETCH;
                unique case (op)
                    OP_HALT: begin
                        st_d.halted = 1'b1;
                        st_d.phase  = st_q.phase;
                    end
                    OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: begin
                        rf_we    = 1'b1;
                        rf_wdata = alu_y;
                    end
                    OP_LDA: begin
                        rf_we    = 1'b1;
                        rf_wdata = W'(fld_addr);
                    end
                    OP_LD, OP_LDI: begin
                        rf_we    = 1'b1;
                        rf_wdata = mem_rdata;
                    end
                    OP_ST, OP_STI: mem_we = 1'b1;
                    OP_BZ: if (is_zero) st_d.pc = fld_addr;
                    OP_BP: if (is_pos)  st_d.pc = fld_addr;
                    OP_JR: st_d.pc = ra_val[AW-1:0];
                    OP_JAL: begin
                        rf_we    = 1'b1;
                        rf_wdata = W'(st_q.pc);
                        st_d.pc  = fld_addr;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.halted <= 1'b0;
            st_q.phase  <= PH_FETCH;
            st_q.ir     <= '0;
            st_q.pc     <= START;
        end else begin
            st_q <= st_d;
        end
    end

    tp_regfile #(.W(W), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (rf_ra),
        .ra_data (ra_val),
        .rb_addr (fld_tgt),
        .rb_data (rb_val),
        .we      (rf_we),
        .waddr   (fld_dst),
        .wdata   (rf_wdata)
    );

    tp_alu #(.W(W)) u_alu (
        .sel (alu_sel),
        .a   (ra_val),
        .b   (rb_val),
        .y   (alu_y)
    );

    tp_memory #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .core_addr  (mem_addr),
        .core_rdata (mem_rdata),
        .core_we    (mem_we),
        .core_wdata (ra_val),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_wdata   (ld_wdata),
        .ld_rdata   (ld_rdata)
    );

    assign halted = st_q.halted;
    assign pc_dbg = st_q.pc;

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.halted && st_q.phase == PH_FETCH)
        |=> (st_q.pc == $past(st_q.pc) + 1'b1 && st_q.phase == PH_EXEC));

    // R2
    exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.halted && st_q.phase == PH_EXEC && op != OP_HALT)
        |=> (st_q.phase == PH_FETCH));

    // R3
    write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_we) |-> (st_q.phase == PH_EXEC && !st_q.halted));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halted |=> (st_q.halted && $stable(st_q.pc) && $stable(st_q.phase)));
endmodule

// File: tb/twophase_cpu_tb.sv
module twophase_cpu_tb;
    localparam logic [7:0] START = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = 8'h0;
    logic [15:0] ld_wdata = 16'h0;
    logic [15:0] ld_rdata;
    logic        halted;
    logic [7:0]  pc_dbg;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic [15:0] img [256];

    always #2 clk = ~clk;

    twophase_cpu #(.START(START)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .halted(halted), .pc_dbg(pc_dbg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] d,
                                        input logic [3:0] s, input logic [3:0] t);
        return {op, d, s, t};
    endfunction

    function automatic logic [15:0] alu_ref(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'h1: return a + b;
            4'h2: return a - b;
            4'h3: return a & b;
            4'h4: return a ^ b;
            4'h5: return a << b[3:0];
            default: return 16'($signed(a) >>> b[3:0]);
        endcase
    endfunction

    task automatic clear_img();
        for (int k = 0; k < 256; k++) img[k] = 16'h0000;
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        ld_addr = a;
        #1;
        v = ld_rdata;
    endtask

    // Loads the image under reset, checks reset state, runs until halt.
    task automatic run(input int n_instr, input string tag);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 256; k++) begin
            ld_we = 1'b1; ld_addr = 8'(k); ld_wdata = img[k];
            @(negedge clk);
        end
        ld_we = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pc_dbg == START, {"R1 reset pc ", tag}, 32'(pc_dbg), 32'(START));
        chk(halted == 1'b0, {"R1 reset halted ", tag}, 32'(halted), 32'd0);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        // R2: two edges per instruction
        chk(cyc == 2 * n_instr, {"R2 cycle count ", tag}, 32'(cyc), 32'(2 * n_instr));
    endtask

    task automatic expect_mem(input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        peek(a, v);
        chk(v === exp, tag, 32'(v), 32'(exp));
    endtask

    initial begin
        logic [15:0] a, b, v, e;
        logic [3:0]  op;
        logic [7:0]  pc_hold;
        bit          take;
        void'($urandom(32'd20240611));

        // R4: random ALU operations
        for (int i = 0; i < 36; i++) begin
            op = 4'(1 + ($urandom % 6));
            a  = 16'($urandom);
            b  = (i % 3 == 0) ? 16'($urandom % 16) : 16'($urandom);
            clear_img();
            img[8'hE0] = a; img[8'hE1] = b;
            img[8'h10] = 16'h81E0;
            img[8'h11] = 16'h82E1;
            img[8'h12] = enc(op, 4'h3, 4'h1, 4'h2);
            img[8'h13] = 16'h93F0;
            img[8'h14] = 16'h0000;
            run(5, "R4 alu");
            expect_mem(8'hF0, alu_ref(op, a, b), "R4 alu result");
            chk(pc_dbg == 8'h15, "R2 pc after halt", 32'(pc_dbg), 32'h15);
        end

        // R3: same register as source and destination
        clear_img();
        img[8'hE0] = 16'h1357;
        img[8'h10] = 16'h81E0; img[8'h11] = 16'h1111;
        img[8'h12] = 16'h91F0; img[8'h13] = 16'h0000;
        run(4, "R3");
        expect_mem(8'hF0, 16'h26AE, "R3 R1=R1+R1");

        // R9: writes to R0 ignored
        clear_img();
        img[8'hE0] = 16'hBEEF;
        img[8'h10] = 16'h70AB; img[8'h11] = 16'h80E0;
        img[8'h12] = 16'h90F0; img[8'h13] = 16'h1200;
        img[8'h14] = 16'h92F1; img[8'h15] = 16'h0000;
        img[8'hF0] = 16'hFFFF; img[8'hF1] = 16'hFFFF;
        run(6, "R9");
        expect_mem(8'hF0, 16'h0000, "R9 R0 store");
        expect_mem(8'hF1, 16'h0000, "R9 R0+R0");

        // R5: load address and direct load/store
        clear_img();
        img[8'hE2] = 16'hA5C3;
        img[8'h10] = 16'h75C3; img[8'h11] = 16'h95F0;
        img[8'h12] = 16'h86E2; img[8'h13] = 16'h96F1;
        img[8'h14] = 16'h0000;
        run(5, "R5");
        expect_mem(8'hF0, 16'h00C3, "R5 load address");
        expect_mem(8'hF1, 16'hA5C3, "R5 load/store");

        // R6: indirect access, upper byte of R[t] ignored
        clear_img();
        img[8'hE0] = 16'h12E5; img[8'hE5] = 16'h6A6A; img[8'hE1] = 16'hFFF7;
        img[8'h10] = 16'h81E0; img[8'h11] = 16'hA201;
        img[8'h12] = 16'h83E1; img[8'h13] = 16'hB203;
        img[8'h14] = 16'h0000;
        run(5, "R6");
        expect_mem(8'hF7, 16'h6A6A, "R6 indirect load/store");

        // R7: branches over zero, positive, negative, max and -1
        for (int i = 0; i < 10; i++) begin
            case (i % 5)
                0: a = 16'h0000;
                1: a = 16'h0001;
                2: a = 16'h8000;
                3: a = 16'h7FFF;
                default: a = 16'hFFFF;
            endcase
            op = (i < 5) ? 4'hC : 4'hD;
            take = (op == 4'hC) ? (a == 16'h0) : (a != 16'h0 && !a[15]);
            clear_img();
            img[8'hE0] = a;
            img[8'h10] = 16'h81E0; img[8'h11] = enc(op, 4'h1, 4'h2, 4'h0);
            img[8'h12] = 16'h7511; img[8'h13] = 16'h95F0; img[8'h14] = 16'h0000;
            img[8'h20] = 16'h7522; img[8'h21] = 16'h95F0; img[8'h22] = 16'h0000;
            run(5, "R7");
            e = take ? 16'h0022 : 16'h0011;
            expect_mem(8'hF0, e, "R7 branch path");
            chk(pc_dbg == (take ? 8'h23 : 8'h15), "R7 branch pc", 32'(pc_dbg), take ? 32'h23 : 32'h15);
        end

        // R8: jump and link
        clear_img();
        img[8'h10] = 16'hFF30; img[8'h30] = 16'h9FF0; img[8'h31] = 16'h0000;
        run(3, "R8 jal");
        expect_mem(8'hF0, 16'h0011, "R8 link value");
        chk(pc_dbg == 8'h32, "R8 jal pc", 32'(pc_dbg), 32'h32);

        // R8: jump register uses low byte
        clear_img();
        img[8'hE0] = 16'h7740;
        img[8'h10] = 16'h81E0; img[8'h11] = 16'hE100;
        img[8'h40] = 16'h7599; img[8'h41] = 16'h95F0; img[8'h42] = 16'h0000;
        run(5, "R8 jr");
        expect_mem(8'hF0, 16'h0099, "R8 jr path");
        chk(pc_dbg == 8'h43, "R8 jr pc", 32'(pc_dbg), 32'h43);

        // R10: immediate halt holds PC and blocks stores
        clear_img();
        img[8'h10] = 16'h0000; img[8'h11] = 16'h95F0;
        img[8'hF0] = 16'h5A5A;
        run(1, "R10");
        pc_hold = pc_dbg;
        chk(pc_hold == 8'h11, "R10 halt pc", 32'(pc_hold), 32'h11);
        repeat (8) @(negedge clk);
        chk(halted == 1'b1, "R10 halted sticky", 32'(halted), 32'd1);
        chk(pc_dbg == pc_hold, "R10 pc frozen", 32'(pc_dbg), 32'(pc_hold));
        expect_mem(8'hF0, 16'h5A5A, "R10 no store after halt");

        // R11: load port readback
        for (int i = 0; i < 6; i++) begin
            a = 16'($urandom % 256);
            peek(a[7:0], v);
            chk(v === img[a[7:0]], "R11 load readback", 32'(v), 32'(img[a[7:0]]));
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule